// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Line Status

This block takes asynchronous serial characters from one input line and hands them to a host as parallel bytes. A strobe that pulses once per oversample period (sixteen pulses per bit) paces all timing. The receiver starts timing on the first falling level it sees while idle, and it confirms the start bit at its centre, so a short low spike on the line never turns into a character. It then samples five to eight data bits, an optional parity bit and one stop bit, each sixteen strobes after the previous sample.

The finished character goes into a holding register. A four-bit status word reports whether a character is waiting, whether an unread character was overwritten, and whether the newest character had a parity or stop-bit fault. The host clears these flags with single-cycle read strobes. The data length, the parity enable and the parity sense are static configuration inputs. A two-stage synchronizer brings the serial line into the clock domain.

Top module: `uart_rx_status`

## Requirements
- R1: While idle, a low level on the synchronized line at a strobe starts the start-bit timer, and the line is sampled again seven strobes later. If it is high then, the receiver returns to idle, and the holding register and status word do not change.
- R2: `cfg_len` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least-significant first and land in `hold_data` from bit 0 upward. Bits above the selected length read as 0.
- R3: Each data, parity and stop sample is taken 16 strobes after the previous sample. All loads of the holding register happen in the cycle after a strobe.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` = 1 expects even parity over data plus parity bit, and 0 expects odd parity. A mismatch sets `line_stat[2]`. With `cfg_par_en` = 0, no parity bit is expected and `line_stat[2]` stays 0.
- R5: A low level at the stop-bit sample sets `line_stat[3]`. The character is still loaded.
- R6: After the stop sample, the character is loaded into `hold_data` and `line_stat[0]` (data ready) becomes 1.
- R7: A one-cycle pulse on `hold_rd` clears `line_stat[0]` unless a new character loads in that same cycle.
- R8: If a character loads while `line_stat[0]` is 1 and no `hold_rd` is present in that cycle, `line_stat[1]` (overrun) becomes 1. It stays 1 until a status read.
- R9: A one-cycle pulse on `stat_rd` clears `line_stat[3:1]`. A newly loaded character replaces bits 3 and 2 with its own parity and stop results.
- R10: While `rst` is high, and after it is released, `hold_data` and `line_stat` are all zero.
- R11: After the stop sample the receiver is idle at once, so a start bit that directly follows a full stop bit is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversample strobe, 16 per bit period |
| serial_in | input | 1 | Asynchronous serial line, idles high |
| cfg_len | input | 2 | Data length select (00=5 … 11=8 bits) |
| cfg_par_en | input | 1 | 1 = a parity bit follows the data |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| hold_rd | input | 1 | Host read strobe for the holding register |
| stat_rd | input | 1 | Host read strobe for the status word |
| hold_data | output | 8 | Received character, zero-extended |
| line_stat | output | 4 | {framing, parity, overrun, data ready} |

## Verification
The bench sweeps every data length against no parity, odd parity and even parity, using all-zeros, all-ones, alternating and length-dependent data words. These patterns separate bit-order and zero-extension faults from parity-polarity faults. Low spikes of two and five strobes, which both end before the centre sample, show that the start bit is confirmed at its centre rather than accepted on the edge. Flipped parity bits, a shortened low stop bit, two unread characters in a row, and a clean character after a faulty one show the set, clear and replace rules of each status flag, and also show that a start bit directly after a stop bit is received.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // One received character with its own error results
  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
    logic       frm_err;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx,
  input  logic [1:0] len_sel,
  input  logic     par_en,
  input  logic     par_even,
  output logic     xfer,
  output rx_char_t ch
);
  localparam int CNT_W      = $clog2(OSR);
  localparam int CW         = $clog2(DATA_W + 1);
  localparam int START_LAST = OSR / 2 - 2;

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [CW-1:0]     bidx;
  logic [DATA_W-1:0] sr;
  logic              pbit;
  logic [CW-1:0]     nbits;
  logic [DATA_W-1:0] aligned;
  logic              exp_par;
  logic              at_bit_end;

  assign nbits      = CW'(MIN_BITS) + CW'(len_sel);
  assign aligned    = sr >> (CW'(DATA_W) - nbits);
  assign exp_par    = par_even ? ^aligned : ~^aligned;
  assign at_bit_end = (cnt == CNT_W'(OSR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sr    <= '0;
      pbit  <= 1'b0;
      xfer  <= 1'b0;
      ch    <= '0;
    end else begin
      xfer <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == CNT_W'(START_LAST)) begin
              cnt  <= '0;
              bidx <= '0;
              state <= rx ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_bit_end) begin
              cnt <= '0;
              sr  <= {rx, sr[DATA_W-1:1]};
              if (bidx == nbits - CW'(1)) begin
                bidx  <= '0;
                state <= par_en ? RX_PAR : RX_STOP;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_bit_end) begin
              cnt   <= '0;
              pbit  <= rx;
              state <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_bit_end) begin
              cnt        <= '0;
              xfer       <= 1'b1;
              ch.data    <= 8'(aligned);
              ch.par_err <= par_en & (pbit != exp_par);
              ch.frm_err <= ~rx;
              state      <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xfer,
  input  rx_char_t   ch,
  input  logic       hold_rd,
  input  logic       stat_rd,
  output logic [7:0] hold_data,
  output logic [3:0] line_stat
);
  logic dr, oe, pe, fe;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      dr <= 1'b0;
      oe <= 1'b0;
      pe <= 1'b0;
      fe <= 1'b0;
    end else if (xfer) begin
      hold_data <= ch.data;
      dr <= 1'b1;
      oe <= (dr & ~hold_rd) | (oe & ~stat_rd);
      pe <= ch.par_err;
      fe <= ch.frm_err;
    end else begin
      if (hold_rd) dr <= 1'b0;
      if (stat_rd) begin
        oe <= 1'b0;
        pe <= 1'b0;
        fe <= 1'b0;
      end
    end
  end

  assign line_stat = {fe, pe, oe, dr};
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       serial_in,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       hold_rd,
  input  logic       stat_rd,
  output logic [7:0] hold_data,
  output logic [3:0] line_stat
);
  localparam int DATA_W = 8;

  logic     rx_s;
  logic     xfer;
  rx_char_t ch;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(serial_in), .q(rx_s)
  );

  uart_rx_fsm #(.OSR(OSR), .DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s),
    .len_sel(cfg_len), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .xfer(xfer), .ch(ch)
  );

  uart_rx_hold u_hold (
    .clk(clk), .rst(rst), .xfer(xfer), .ch(ch),
    .hold_rd(hold_rd), .stat_rd(stat_rd),
    .hold_data(hold_data), .line_stat(line_stat)
  );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick16,
  input logic       xfer,
  input logic       hold_rd,
  input logic       stat_rd,
  input logic [1:0] cfg_len,
  input logic [7:0] hold_data,
  input logic [3:0] line_stat
);
  assert_dr_set_R6: assert property (@(posedge clk) disable iff (rst)
    xfer |=> line_stat[0]);

  assert_dr_from_load_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(line_stat[0]) |-> $past(xfer));

  assert_dr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_rd && !xfer) |=> !line_stat[0]);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer && line_stat[0] && !hold_rd) |=> line_stat[1]);

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !xfer) |=> (line_stat[3:1] == 3'b000));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer && cfg_len == 2'b00) |=> (hold_data[7:5] == 3'b000));

  assert_load_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    xfer |-> $past(tick16));

  assert_load_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk(clk), .rst(rst), .tick16(tick16), .xfer(xfer),
  .hold_rd(hold_rd), .stat_rd(stat_rd), .cfg_len(cfg_len),
  .hold_data(hold_data), .line_stat(line_stat)
);

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       serial_in = 1'b1;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       hold_rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] hold_data;
  logic [3:0] line_stat;
  logic [1:0] tdiv = 2'd0;
  int nchk = 0;
  int nfail = 0;

  localparam int BITCLK = 64;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      tdiv   <= 2'd0;
      tick16 <= 1'b0;
    end else begin
      tdiv   <= tdiv + 2'd1;
      tick16 <= (tdiv == 2'd3);
    end
  end

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst(rst), .tick16(tick16), .serial_in(serial_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .hold_rd(hold_rd), .stat_rd(stat_rd),
    .hold_data(hold_data), .line_stat(line_stat)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int clocks);
    serial_in = 1'b1;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    serial_in = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  // nb = data length, pmode 0 none / 1 odd / 2 even
  task automatic send_frame(input int d, input int nb, input int pmode,
                            input bit bad_par, input bit bad_stop);
    logic p;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pmode != 0) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ d[i];
      if (pmode == 1) p = ~p;
      if (bad_par) p = ~p;
      send_bit(p);
    end
    if (bad_stop) begin
      serial_in = 1'b0;
      repeat (48) @(negedge clk);
      idle(80);
    end else begin
      send_bit(1'b1);
    end
  endtask

  task automatic rd_hold();
    hold_rd = 1'b1;
    @(negedge clk);
    hold_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int nb, input int pmode);
    cfg_len      = 2'(nb - 5);
    cfg_par_en   = (pmode != 0);
    cfg_par_even = (pmode == 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int d;
    repeat (6) @(negedge clk);
    chk("R10 reset status", int'(line_stat), 0);
    chk("R10 reset data", int'(hold_data), 0);
    rst = 1'b0;
    idle(20);
    chk("R10 after release status", int'(line_stat), 0);

    // Sweep lengths x parity modes x data patterns
    for (int nb = 5; nb <= 8; nb++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int k = 0; k < 4; k++) begin
          d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : ((nb * 37 + pm * 11) & 8'hFF);
          set_cfg(nb, pm);
          send_frame(d, nb, pm, 1'b0, 1'b0);
          idle(32);
          chk("R2 R3 data value", int'(hold_data), d & ((1 << nb) - 1));
          chk("R6 data ready set", int'(line_stat[0]), 1);
          chk("R4 no parity error", int'(line_stat[2]), 0);
          chk("R5 no framing error", int'(line_stat[3]), 0);
          chk("R8 no overrun", int'(line_stat[1]), 0);
          rd_hold();
          chk("R7 data ready cleared", int'(line_stat[0]), 0);
        end
      end
    end

    // Start-bit noise spikes
    set_cfg(8, 0);
    serial_in = 1'b0;
    repeat (8) @(negedge clk);
    idle(30 * 4);
    chk("R1 short spike ignored status", int'(line_stat), 0);
    chk("R1 short spike data unchanged", int'(hold_data), 8'h5A & 8'hFF ^ 8'h5A ^ ((8 * 37 + 22) & 8'hFF));
    serial_in = 1'b0;
    repeat (20) @(negedge clk);
    idle(30 * 4);
    chk("R1 five-tick spike ignored", int'(line_stat), 0);
    send_frame(8'h96, 8, 0, 1'b0, 1'b0);
    idle(32);
    chk("R1 frame after spike", int'(hold_data), 8'h96);
    rd_hold();

    // Parity errors, both senses
    for (int pm = 1; pm < 3; pm++) begin
      set_cfg(7, pm);
      send_frame(8'h4B, 7, pm, 1'b1, 1'b0);
      idle(32);
      chk("R4 parity error set", int'(line_stat[2]), 1);
      chk("R4 data kept", int'(hold_data), 8'h4B);
      rd_hold();
      chk("R9 parity flag held after data read", int'(line_stat[2]), 1);
      rd_stat();
      chk("R9 parity flag cleared", int'(line_stat[3:1]), 0);
    end

    // Framing error
    set_cfg(6, 0);
    send_frame(8'h2D, 6, 0, 1'b0, 1'b1);
    chk("R5 framing error set", int'(line_stat[3]), 1);
    chk("R5 character loaded", int'(hold_data), 8'h2D);
    chk("R5 data ready", int'(line_stat[0]), 1);
    rd_hold();
    rd_stat();
    chk("R9 framing flag cleared", int'(line_stat[3]), 0);

    // New character replaces stale parity result
    set_cfg(8, 2);
    send_frame(8'h11, 8, 2, 1'b1, 1'b0);
    idle(32);
    chk("R4 even parity mismatch", int'(line_stat[2]), 1);
    rd_hold();
    send_frame(8'h33, 8, 2, 1'b0, 1'b0);
    idle(32);
    chk("R9 parity flag replaced", int'(line_stat[2]), 0);
    rd_hold();
    rd_stat();

    // Back-to-back: start right after stop, read in between
    set_cfg(8, 0);
    send_frame(8'hC3, 8, 0, 1'b0, 1'b0);
    chk("R11 first frame", int'(hold_data), 8'hC3);
    rd_hold();
    send_frame(8'h3C, 8, 0, 1'b0, 1'b0);
    idle(8);
    chk("R11 second frame", int'(hold_data), 8'h3C);
    chk("R11 no overrun when read", int'(line_stat[1]), 0);
    rd_hold();

    // Overrun: two characters without a read
    send_frame(8'h81, 8, 0, 1'b0, 1'b0);
    send_frame(8'h7E, 8, 0, 1'b0, 1'b0);
    idle(8);
    chk("R8 overrun set", int'(line_stat[1]), 1);
    chk("R8 newest data", int'(hold_data), 8'h7E);
    rd_hold();
    chk("R8 overrun survives data read", int'(line_stat[1:0]), 2'b10);
    rd_stat();
    chk("R9 overrun cleared", int'(line_stat), 0);

    summary();
    $finish;
  end
endmodule